// File: doc/BRIEF.md
# Low-Rate Avionics Serial Word Transmitter

This block sends 12-bit data words over a slow avionics serial link. Software stages each word in two writes, the low byte first and then the upper four bits. Writing the upper bits commits the word to a holding register. At each word-slot boundary the holding register is emptied into a parallel-to-serial shifter. The shifter sends the word least significant bit first, one bit per cell. Because of the separate holding register, software can stage the next word while the current one is still on the line.

The bit timing comes from a programmable divider that has its own enable bit. A mode field selects one of three line codes. Bipolar return-to-zero drives one pair of lines, and the two bi-phase codes drive a separate differential pair. A transmit-enable input forces every line low without stopping the shifter. Each transfer into the shifter raises a sticky interrupt. If a slot boundary finds the holding register empty, the block sends an idle slot and sets an underrun flag.

Top module: `lowrate_tx`

## Requirements
- R1: A `wr_lo` strobe stores `wr_data[7:0]` as word bits 7:0 and commits nothing. A `wr_hi` strobe stores `wr_data[3:0]` as word bits 11:8 and marks the holding register full. A word committed while the previous word is still shifting is sent in the very next slot, with no gap.
- R2: `div_cfg[7]` enables the bit clock and `div_cfg[6:0]` holds the divide value D. Each half cell lasts D+1 clock cycles and each bit cell has two halves. While `div_cfg[7]` is 0 the transmitter does not advance and does not consume the holding register.
- R3: Each word slot is 12 bit cells long. The bits go out least significant first, and slots follow each other back to back.
- R4: `irq` becomes 1 one cycle after a word moves into the shifter and stays at 1 until an `irq_clr` pulse. Exactly one interrupt is raised per word sent.
- R5: If a slot boundary finds the holding register empty, the block sends an idle slot of 12 cells and sets `underrun`. The idle slot has no pulses in return-to-zero mode and encodes zeros in the bi-phase modes. `underrun` is cleared by the next `wr_hi` strobe.
- R6: Mode 3'b000 selects bipolar return-to-zero. In the first half of a cell, a 1 drives `rz_a` high and a 0 drives `rz_b` high. Both lines are low in the second half, and both stay low for the whole of an idle slot. `bp_a` and `bp_b` are held low in this mode.
- R7: Mode 3'b001 selects FM0. `bp_a` toggles at the start of every cell, and toggles again mid-cell when the bit is 0. `bp_b` is the complement of `bp_a`, and `rz_a` and `rz_b` are held low.
- R8: Mode 3'b010 selects FM1. It follows the same rules as R7, except that the mid-cell toggle marks a 1.
- R9: Any other mode value holds all four lines low while words are still consumed and interrupts still raised.
- R10: While `tx_en` is 0, all four lines are held low. The shifter, the interrupt and the underrun logic carry on running.
- R11: After reset, `irq`, `underrun` and all four lines are 0, the holding register is empty, and the first enabled tick is a slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Strobe that stages the low byte of a word |
| wr_hi | input | 1 | Strobe that stages the high nibble and commits the word |
| wr_data | input | 8 | Write data for both strobes |
| div_cfg | input | 8 | Bit 7 enables the bit clock; bits 6:0 set the half-cell divide value |
| mode | input | 3 | Line-code select |
| tx_en | input | 1 | Enables the line outputs |
| irq_clr | input | 1 | Pulse that clears the interrupt |
| irq | output | 1 | Sticky word-transfer interrupt |
| underrun | output | 1 | Sticky flag: an idle slot was sent |
| rz_a | output | 1 | Return-to-zero line for ones |
| rz_b | output | 1 | Return-to-zero line for zeros |
| bp_a | output | 1 | Bi-phase line, true polarity |
| bp_b | output | 1 | Bi-phase line, complement |

## Verification
The embedded assertions check several rules on every cycle:
- the two return-to-zero lines are never high together;
- the bi-phase pair is always complementary while it is driven;
- the lines are silent whenever transmit is disabled;
- the shifter state freezes between ticks;
- each transfer is followed by an interrupt;
- the bi-phase level changes at every cell boundary.

Some behaviour can only be shown by the bench scenarios, which decode the lines back into words. This covers least-significant-first order, the choice of mid-cell toggle between FM0 and FM1, and the exact half-cell length for each divide value. It also covers back-to-back double buffering, the idle slot with its underrun flag, and the fact that a low-byte write alone commits no word.

// File: rtl/lrtx_pkg.sv
// Shared constants and line-code encoding for the low-rate transmitter.
package lrtx_pkg;
    // Line-code selector values carried on the mode input.
    typedef enum logic [2:0] {
        LC_RZ  = 3'b000,
        LC_FM0 = 3'b001,
        LC_FM1 = 3'b010
    } line_code_e;
endpackage

// File: rtl/lrtx_baud.sv
// Half-cell tick generator.
// Emits a one-cycle tick every DIV+1 clocks while enabled, and holds the
// count at zero while disabled. Assumes the divide value is quasi-static;
// if it shrinks below the current count, the next cycle wraps.
module lrtx_baud #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt;

    assign tick = en && (dcnt >= div);

    // Divider counter: wraps on a tick, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      dcnt <= '0;
        else if (!en)    dcnt <= '0;
        else if (tick)   dcnt <= '0;
        else             dcnt <= dcnt + 1'b1;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dcnt == '0));
endmodule

// File: rtl/lrtx_hold.sv
// Holding register for one word.
// The low byte is staged first; the high part commits the word and sets
// full. A take from the shifter empties the register. A commit in the same
// cycle as a take leaves the register full with the new word.
module lrtx_hold #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    input  logic              take,
    output logic [WORD_W-1:0] word,
    output logic              full
);
    localparam int HI_W = WORD_W - 8;

    logic [7:0]      lo_q;
    logic [HI_W-1:0] hi_q;
    logic            full_q;

    assign word = {hi_q, lo_q};
    assign full = full_q;

    // Data staging for both halves of the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= wr_data[HI_W-1:0];
        end
    end

    // Full flag: set by commit, cleared by take; commit wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      full_q <= 1'b0;
        else if (wr_hi)  full_q <= 1'b1;
        else if (take)   full_q <= 1'b0;
    end

    // R1
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> full_q);
    // R1
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(take));
endmodule

// File: rtl/lrtx_shift.sv
// Parallel-to-serial shifter with cell/slot sequencing.
// Each tick advances one half cell. At the end of the last cell of a slot,
// the shifter loads the holding register if it is full; otherwise it
// starts an idle slot and flags underrun. It also keeps the bi-phase level,
// which toggles at every cell start and mid-cell according to the FM flavour.
module lrtx_shift #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              full,
    input  logic [WORD_W-1:0] word,
    input  logic              fm0_sel,
    input  logic              fm1_sel,
    input  logic              wr_hi,
    input  logic              irq_clr,
    output logic              take,
    output logic              cur_bit,
    output logic              valid,
    output logic              half,
    output logic              lvl,
    output logic              irq,
    output logic              underrun
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic              half_q, valid_q, lvl_q, irq_q, urun_q;
    logic              boundary, mid_flip;

    assign boundary = tick && half_q && (cnt == LAST);
    assign take     = boundary && full;
    assign mid_flip = (fm1_sel && shreg[0]) || (fm0_sel && !shreg[0]);
    assign cur_bit  = shreg[0];
    assign valid    = valid_q;
    assign half     = half_q;
    assign lvl      = lvl_q;
    assign irq      = irq_q;
    assign underrun = urun_q;

    // Cell sequencing, shifting, slot loading and bi-phase level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= LAST;
            half_q  <= 1'b1;
            shreg   <= '0;
            valid_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else if (tick) begin
            if (half_q) begin
                half_q <= 1'b0;
                lvl_q  <= ~lvl_q;
                if (cnt == LAST) begin
                    cnt     <= '0;
                    shreg   <= full ? word : '0;
                    valid_q <= full;
                end else begin
                    cnt   <= cnt + 1'b1;
                    shreg <= shreg >> 1;
                end
            end else begin
                half_q <= 1'b1;
                if (mid_flip) lvl_q <= ~lvl_q;
            end
        end
    end

    // Interrupt: set on each transfer, held until cleared; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (take)     irq_q <= 1'b1;
        else if (irq_clr)  irq_q <= 1'b0;
    end

    // Underrun: set on an empty boundary, cleared by a commit; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                  urun_q <= 1'b0;
        else if (boundary && !full)  urun_q <= 1'b1;
        else if (wr_hi)              urun_q <= 1'b0;
    end

    // R4
    irq_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> irq_q);
    // R2
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(half_q) && $stable(shreg)));
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R5
    underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !full) |=> (urun_q && !valid_q));
    // R7
    cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_q) |=> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/lrtx_enc.sv
// Line encoder.
// Maps the shifter state onto the return-to-zero pair or the bi-phase
// pair according to the mode, and silences everything when transmit is off
// or the mode is unassigned. Purely combinational.
module lrtx_enc
    import lrtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       tx_en,
    input  logic       half,
    input  logic       cur_bit,
    input  logic       valid,
    input  logic       lvl,
    output logic       rz_a,
    output logic       rz_b,
    output logic       bp_a,
    output logic       bp_b
);
    // Output selection per line code.
    always_comb begin
        rz_a = 1'b0;
        rz_b = 1'b0;
        bp_a = 1'b0;
        bp_b = 1'b0;
        if (tx_en) begin
            case (mode)
                LC_RZ: begin
                    rz_a = !half && valid && cur_bit;
                    rz_b = !half && valid && !cur_bit;
                end
                LC_FM0, LC_FM1: begin
                    bp_a = lvl;
                    bp_b = !lvl;
                end
                default: ;
            endcase
        end
    end

    // R6
    rz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rz_a && rz_b));
    // R10
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!rz_a && !rz_b && !bp_a && !bp_b));
    // R7
    bp_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_a || bp_b) |-> (bp_a != bp_b));
endmodule

// File: rtl/lowrate_tx.sv
// Top level of the low-rate serial word transmitter.
// Ties the divider, holding register, shifter and encoder together.
// Assumes the host issues single-cycle strobes and keeps div_cfg and mode
// stable while a slot is in flight.
module lowrate_tx
    import lrtx_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int DIV_W  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lo,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic [7:0] div_cfg,
    input  logic [2:0] mode,
    input  logic       tx_en,
    input  logic       irq_clr,
    output logic       irq,
    output logic       underrun,
    output logic       rz_a,
    output logic       rz_b,
    output logic       bp_a,
    output logic       bp_b
);
    logic              tick, take, full, cur_bit, valid, half, lvl;
    logic [WORD_W-1:0] word;
    logic              fm0_sel, fm1_sel;

    assign fm0_sel = (mode == LC_FM0);
    assign fm1_sel = (mode == LC_FM1);

    lrtx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .en(div_cfg[7]),
        .div(div_cfg[DIV_W-1:0]), .tick(tick)
    );

    lrtx_hold #(.WORD_W(WORD_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .take(take), .word(word), .full(full)
    );

    lrtx_shift #(.WORD_W(WORD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .full(full), .word(word),
        .fm0_sel(fm0_sel), .fm1_sel(fm1_sel), .wr_hi(wr_hi),
        .irq_clr(irq_clr), .take(take), .cur_bit(cur_bit), .valid(valid),
        .half(half), .lvl(lvl), .irq(irq), .underrun(underrun)
    );

    lrtx_enc enc_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en),
        .half(half), .cur_bit(cur_bit), .valid(valid), .lvl(lvl),
        .rz_a(rz_a), .rz_b(rz_b), .bp_a(bp_a), .bp_b(bp_b)
    );

    // R9
    unused_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LC_RZ && mode != LC_FM0 && mode != LC_FM1)
            |-> (!rz_a && !rz_b && !bp_a && !bp_b));
endmodule

// File: tb/lowrate_tx_tb.sv
// Self-checking bench: sweeps line codes and divide values, decodes the
// lines back into words and compares them with the words written.
module lowrate_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0, tx_en = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = '0, div_cfg = '0;
    logic [2:0] mode = '0;
    logic       irq, underrun, rz_a, rz_b, bp_a, bp_b;

    always #5 clk = ~clk;

    lowrate_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .div_cfg(div_cfg), .mode(mode), .tx_en(tx_en),
        .irq_clr(irq_clr), .irq(irq), .underrun(underrun),
        .rz_a(rz_a), .rz_b(rz_b), .bp_a(bp_a), .bp_b(bp_b)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [11:0] words [8];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_lo = 0; wr_hi = 0; irq_clr = 0; div_cfg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [11:0] w);
        @(negedge clk); wr_data = w[7:0]; wr_lo = 1'b1;
        @(negedge clk); wr_lo = 1'b0; wr_data = {4'h0, w[11:8]}; wr_hi = 1'b1;
        @(negedge clk); wr_hi = 1'b0;
    endtask

    task automatic wait_take_clear();
        while (!irq) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Feeds words 1..7 as each transfer is signalled (R1 double buffering).
    task automatic writer();
        for (int i = 1; i < 8; i++) begin
            wait_take_clear();
            write_word(words[i]);
        end
        wait_take_clear();
    endtask

    // Decodes return-to-zero pulses and checks each pulse length (R6, R2, R3).
    task automatic decode_rz(input int p);
        for (int w = 0; w < 8; w++) begin
            logic [11:0] got = '0;
            int bad_w = 0;
            for (int c = 0; c < 12; c++) begin
                int width = 0;
                while (!(rz_a || rz_b)) @(negedge clk);
                got[c] = rz_a;
                if (bp_a || bp_b) bad_w++;
                while (rz_a || rz_b) begin width++; @(negedge clk); end
                if (width != p) bad_w++;
            end
            chk(got == words[w], "R3 R6 rz word", got, words[w]);
            chk(bad_w == 0, "R2 R6 rz pulse width/pair", bad_w, 0);
        end
    endtask

    // Decodes bi-phase cells at known offsets from the first cell edge (R7, R8).
    task automatic decode_fm(input int p, input bit fm1);
        while (!bp_a) @(negedge clk);
        for (int w = 0; w < 8; w++) begin
            logic [11:0] got = '0;
            int bad_e = 0;
            for (int c = 0; c < 12; c++) begin
                logic a1, a2;
                a1 = bp_a;
                if (bp_b == bp_a || rz_a || rz_b) bad_e++;
                repeat (p) @(negedge clk);
                a2 = bp_a;
                repeat (p) @(negedge clk);
                if (bp_a == a2) bad_e++;
                got[c] = fm1 ? (a1 != a2) : (a1 == a2);
            end
            chk(got == words[w], fm1 ? "R8 fm1 word" : "R7 fm0 word", got, words[w]);
            chk(bad_e == 0, "R7 R2 cell edges/pair", bad_e, 0);
        end
    endtask

    task automatic run_code(input logic [2:0] m, input int d);
        int quiet = 0;
        do_reset();
        mode = m; tx_en = 1'b1;
        write_word(words[0]);
        div_cfg = {1'b1, 7'(d)};
        fork
            writer();
            if (m == 3'b000) decode_rz(d + 1);
            else decode_fm(d + 1, m == 3'b010);
        join
        while (!underrun) @(negedge clk);
        chk(underrun == 1'b1, "R5 underrun set", underrun, 1);
        if (m == 3'b000) begin
            repeat (24 * (d + 1)) begin
                if (rz_a || rz_b) quiet++;
                @(negedge clk);
            end
            chk(quiet == 0, "R5 idle slot silent", quiet, 0);
        end
        div_cfg = '0;
        write_word(12'h0F0);
        @(negedge clk);
        chk(underrun == 1'b0, "R5 underrun cleared by commit", underrun, 0);
    endtask

    task automatic run_silent(input logic [2:0] m, input bit en, input string tag);
        int loud = 0;
        do_reset();
        mode = m; tx_en = en;
        write_word(12'hA5A);
        div_cfg = 8'h81;
        repeat (200) begin
            if (rz_a || rz_b || bp_a || bp_b) loud++;
            @(negedge clk);
        end
        chk(loud == 0, tag, loud, 0);
        chk(irq == 1'b1, {tag, " word still consumed (R4)"}, irq, 1);
    endtask

    initial begin
        words[0] = 12'h000; words[1] = 12'hFFF; words[2] = 12'hA5C; words[3] = 12'h3E1;
        words[4] = 12'h001; words[5] = 12'h800; words[6] = 12'h555; words[7] = 12'hAAA;

        // R11 reset state
        do_reset();
        chk({irq, underrun, rz_a, rz_b, bp_a, bp_b} == 6'b0, "R11 reset outputs",
            {irq, underrun, rz_a, rz_b, bp_a, bp_b}, 0);

        // R2 disabled bit clock consumes nothing; R1 low byte alone commits nothing
        mode = 3'b000; tx_en = 1'b1;
        @(negedge clk); wr_data = 8'h3C; wr_lo = 1'b1;
        @(negedge clk); wr_lo = 1'b0;
        div_cfg = 8'h82;
        repeat (150) @(negedge clk);
        chk(irq == 1'b0, "R1 low byte alone no transfer", irq, 0);
        chk(underrun == 1'b1, "R1 R5 empty slot flagged", underrun, 1);
        div_cfg = 8'h03;
        write_word(12'h3C7);
        repeat (200) @(negedge clk);
        chk(irq == 1'b0, "R2 disabled clock no transfer", irq, 0);
        div_cfg = 8'h83;
        repeat (250) @(negedge clk);
        chk(irq == 1'b1, "R2 R4 enabled clock transfers", irq, 1);

        // Sweep of line codes against divide values
        for (int mi = 0; mi < 3; mi++) begin
            for (int di = 0; di < 4; di++) begin
                int dv = (di == 3) ? 5 : di;
                run_code(3'(mi), dv);
            end
        end

        // R9 unassigned mode, R10 transmit disabled
        run_silent(3'b111, 1'b1, "R9 unassigned mode silent");
        run_silent(3'b011, 1'b1, "R9 mode 3 silent");
        run_silent(3'b001, 1'b0, "R10 tx disabled silent");
        run_silent(3'b000, 1'b0, "R10 tx disabled rz silent");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule